// File: doc/BRIEF.md
# Control Word Loader for a Phase-Accumulator Frequency Source

This block assembles a 40-bit programming word for a frequency-synthesis core and holds the committed copy that the core reads. Two load paths fill the same staging register. The parallel path takes five byte transfers from an 8-bit bus, one byte per word-clock edge, under a saturating byte pointer. The serial path shifts one bit per word-clock edge from the top line of the same bus. A rising edge on the update strobe copies the staged word into the active register. That copy supplies the 32-bit tuning word, the 5-bit phase word and the power-down flag.

The word clock and the update strobe are sampled in the system clock domain. Only their rising edges act, so a level that stays high counts once. Staged words that set either reserved control bit are refused at commit time. This keeps codes that could disable the core from reaching the active register.

Top module: `ctrl_word_loader`

## Requirements
- R1: Synchronous active-high reset clears the staging register, the active register and the byte pointer. After reset, all outputs read 0 and the next parallel byte lands in the first byte position.
- R2: Staged word layout: bits [31:0] are the tuning word and bits [33:32] are reserved. Bit 34 is power-down and bits [39:35] are the phase word. The outputs present these fields of the last committed word.
- R3: With `ser_mode`=0, each word-clock rising edge stores `din` at the byte pointer and advances the pointer. The first byte fills bits [39:32], the second [31:24], and so on, and the fifth fills [7:0].
- R4: After five parallel byte stores, further word-clock edges change nothing. This holds until an update edge or a reset returns the pointer to the first byte.
- R5: An update-strobe rising edge copies the staged word to the active register and returns the byte pointer to the first byte. The staged word itself is kept.
- R6: With `ser_mode`=1, each word-clock rising edge shifts `din[7]` into bit 39 and moves every staged bit one place toward bit 0. Bits shifted out of bit 0 are lost. Forty shifts therefore place the first bit sent in bit 0, and a value is sent bit 0 first.
- R7: The active register changes only on an update-strobe rising edge. Holding the update strobe or the word clock high causes one action only.
- R8: When the staged reserved bits [33:32] are not both 0, an update edge leaves the active register unchanged. The byte pointer is still returned to the first byte.
- R9: When a word-clock edge and an update edge arrive in the same cycle, the update takes effect and the word-clock edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wclk_in | input | 1 | Word clock level; rising edges load or shift |
| upd_in | input | 1 | Update strobe level; rising edges commit |
| ser_mode | input | 1 | 0 = byte-parallel load, 1 = serial load through `din[7]` |
| din | input | 8 | Parallel data byte; bit 7 is also the serial data line |
| tuning_word | output | 32 | Committed frequency tuning word |
| phase_word | output | 5 | Committed phase offset word |
| power_down | output | 1 | Committed power-down request |

## Verification
A wrong byte pointer or staging bit stays hidden until the next update edge. The corrupted field then appears at the outputs one clock after that edge, so every test ends with a commit and a compare. A pointer that fails to saturate shows up as a sixth write overwriting a committed byte. A pointer that is not re-armed shows up as a later load landing in the wrong field. Serial ordering faults appear as a bit-reversed or shifted tuning word after forty shifts. Reserved-bit screening is observed by the active value staying as it was across a refused commit.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = 5;
    localparam int WORD_W    = BYTE_W * NUM_BYTES;
    localparam int TUNE_W    = 32;
    localparam int PHASE_W   = 5;
    localparam int RSV_W     = 2;

    // Staged programming word, MSB first
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic               pdn;
        logic [RSV_W-1:0]   rsv;
        logic [TUNE_W-1:0]  tune;
    } ctrl_word_t;

    // Committed fields seen by the synthesis core
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic               pdn;
        logic [TUNE_W-1:0]  tune;
    } active_t;

    typedef enum logic {
        MODE_PAR = 1'b0,
        MODE_SER = 1'b1
    } load_mode_e;

    function automatic logic commit_ok(input ctrl_word_t w);
        return (w.rsv == '0);
    endfunction

    function automatic active_t to_active(input ctrl_word_t w);
        active_t a;
        a.phase = w.phase;
        a.pdn   = w.pdn;
        a.tune  = w.tune;
        return a;
    endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);

    logic lvl_q;

    // During reset track the input so a level held across reset is no edge
    always_ff @(posedge clk) begin
        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q & ~rst;

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise) else $error("edge repeated");   // R7

endmodule

// File: rtl/byte_pointer.sv
module byte_pointer #(
    parameter int NUM_BYTES = 5,
    parameter int PTR_W     = $clog2(NUM_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             clr,
    output logic [PTR_W-1:0] ptr,
    output logic             full
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_BYTES);

    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr_q <= '0;
        end else if (adv && ptr_q != LAST) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr  = ptr_q;
    assign full = (ptr_q == LAST);

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= LAST) else $error("pointer out of range");          // R4
    AST_PTR_SAT: assert property (@(posedge clk) disable iff (rst)
        (full && !clr) |=> full) else $error("pointer left saturation"); // R4
    AST_PTR_REARM: assert property (@(posedge clk) disable iff (rst)
        clr |=> ptr_q == '0) else $error("pointer not re-armed");     // R5

endmodule

// File: rtl/staging_reg.sv
module staging_reg #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 5,
    parameter int PTR_W     = $clog2(NUM_BYTES + 1),
    parameter int WORD_W    = BYTE_W * NUM_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              sh_en,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [BYTE_W-1:0] din,
    input  logic              ser_bit,
    output logic [WORD_W-1:0] word
);

    // Byte slot b holds word bits counted from the top: slot 0 is the MSB byte
    logic [BYTE_W-1:0] slot [NUM_BYTES];
    logic              carry [NUM_BYTES];

    genvar b;
    generate
        for (b = 0; b < NUM_BYTES; b++) begin : g_slot
            localparam int LSB = WORD_W - BYTE_W * (b + 1);

            if (b == 0) begin : g_head
                assign carry[b] = ser_bit;
            end else begin : g_chain
                assign carry[b] = slot[b-1][0];
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    slot[b] <= '0;
                end else if (wr_en && ptr == PTR_W'(b)) begin
                    slot[b] <= din;
                end else if (sh_en) begin
                    slot[b] <= {carry[b], slot[b][BYTE_W-1:1]};
                end
            end

            assign word[LSB +: BYTE_W] = slot[b];

            AST_BYTE_STORE: assert property (@(posedge clk) disable iff (rst)
                (wr_en && ptr == PTR_W'(b)) |=> slot[b] == $past(din))
                else $error("byte not stored");                        // R3
        end
    endgenerate

    AST_SER_ENTRY: assert property (@(posedge clk) disable iff (rst)
        sh_en |=> word[WORD_W-1] == $past(ser_bit))
        else $error("serial bit not entered");                        // R6
    AST_SER_MOVE: assert property (@(posedge clk) disable iff (rst)
        sh_en |=> word[WORD_W-2:0] == $past(word[WORD_W-1:1]))
        else $error("serial shift wrong");                            // R6
    AST_WRITE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sh_en)) else $error("both load paths active");     // R9

endmodule

// File: rtl/ctrl_word_loader.sv
module ctrl_word_loader
    import ldr_pkg::*;
#(
    parameter int DATA_W = ldr_pkg::BYTE_W,
    parameter int N_BYTE = ldr_pkg::NUM_BYTES
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wclk_in,
    input  logic                        upd_in,
    input  logic                        ser_mode,
    input  logic [DATA_W-1:0]           din,
    output logic [ldr_pkg::TUNE_W-1:0]  tuning_word,
    output logic [ldr_pkg::PHASE_W-1:0] phase_word,
    output logic                        power_down
);

    localparam int PTR_W = $clog2(N_BYTE + 1);
    localparam int W_W   = DATA_W * N_BYTE;

    logic             wr_rise;
    logic             up_rise;
    logic             full;
    logic [PTR_W-1:0] ptr;
    logic             par_wr;
    logic             ser_sh;
    logic [W_W-1:0]   stage_bits;
    ctrl_word_t       staged;
    active_t          active_q;
    load_mode_e       mode;

    strobe_edge i_wclk_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (wclk_in),
        .rise (wr_rise)
    );

    strobe_edge i_upd_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (upd_in),
        .rise (up_rise)
    );

    assign mode   = load_mode_e'(ser_mode);
    // Update has priority: a coincident word-clock edge is dropped
    assign par_wr = wr_rise && !up_rise && (mode == MODE_PAR) && !full;
    assign ser_sh = wr_rise && !up_rise && (mode == MODE_SER);

    byte_pointer #(
        .NUM_BYTES (N_BYTE),
        .PTR_W     (PTR_W)
    ) i_ptr (
        .clk  (clk),
        .rst  (rst),
        .adv  (par_wr),
        .clr  (up_rise),
        .ptr  (ptr),
        .full (full)
    );

    staging_reg #(
        .BYTE_W    (DATA_W),
        .NUM_BYTES (N_BYTE),
        .PTR_W     (PTR_W),
        .WORD_W    (W_W)
    ) i_stage (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (par_wr),
        .sh_en   (ser_sh),
        .ptr     (ptr),
        .din     (din),
        .ser_bit (din[DATA_W-1]),
        .word    (stage_bits)
    );

    assign staged = ctrl_word_t'(stage_bits);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
        end else if (up_rise && commit_ok(staged)) begin
            active_q <= to_active(staged);
        end
    end

    assign tuning_word = active_q.tune;
    assign phase_word  = active_q.phase;
    assign power_down  = active_q.pdn;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> active_q == '0) else $error("reset left state");      // R1
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !up_rise |=> $stable(active_q)) else $error("active moved");  // R7
    AST_RSV_REJECT: assert property (@(posedge clk) disable iff (rst)
        (up_rise && staged.rsv != '0) |=> $stable(active_q))
        else $error("reserved code applied");                          // R8
    AST_FULL_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (full && !up_rise) |=> $stable(stage_bits) || $past(ser_sh))
        else $error("write past last byte");                           // R4

endmodule

// File: tb/test_ctrl_word_loader.sv
module test_ctrl_word_loader;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wclk_in = 1'b0;
    logic        upd_in = 1'b0;
    logic        ser_mode = 1'b0;
    logic [7:0]  din = '0;
    logic [31:0] tuning_word;
    logic [4:0]  phase_word;
    logic        power_down;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ctrl_word_loader i_ctrl_word_loader (
        .clk         (clk),
        .rst         (rst),
        .wclk_in     (wclk_in),
        .upd_in      (upd_in),
        .ser_mode    (ser_mode),
        .din         (din),
        .tuning_word (tuning_word),
        .phase_word  (phase_word),
        .power_down  (power_down)
    );

    // {five load bytes, expected staged-format committed word}
    localparam logic [79:0] VEC [5] = '{
        {40'h00_1234_5678, 40'h00_1234_5678},   // R2 tuning only
        {40'hF8_DEAD_BEEF, 40'hF8_DEAD_BEEF},   // R2 phase all ones
        {40'h04_0000_0001, 40'h04_0000_0001},   // R2 power-down bit 34
        {40'h53_AAAA_5555, 40'h04_0000_0001},   // R8 reserved set: unchanged
        {40'h4C_FFFF_FFFF, 40'h4C_FFFF_FFFF}    // R2 mixed fields
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wbyte(input logic [7:0] b);
        din = b; wclk_in = 1'b1; tick(); wclk_in = 1'b0; tick();
    endtask

    task automatic commit();
        upd_in = 1'b1; tick(); upd_in = 1'b0; tick();
    endtask

    task automatic load5(input logic [39:0] w);
        ser_mode = 1'b0;
        for (int k = 4; k >= 0; k--) wbyte(w[k*8 +: 8]);
    endtask

    task automatic sbit(input logic v);
        din = {v, 7'h00}; wclk_in = 1'b1; tick(); wclk_in = 1'b0; tick();
    endtask

    task automatic check(input string req, input logic [39:0] e);
        logic [37:0] got, exp;
        got = {phase_word, power_down, tuning_word};
        exp = {e[39:35], e[34], e[31:0]};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; tick(); tick(); rst = 1'b0; tick();
    endtask

    initial begin
        do_reset();
        check("R1 reset outputs", 40'h0);

        for (int i = 0; i < 5; i++) begin
            load5(VEC[i][79:40]);
            commit();
            check("R3/R2/R8 vector", VEC[i][39:0]);
        end

        // R4: extra writes after five bytes are ignored
        load5(40'h08_0102_0304);
        wbyte(8'hFF); wbyte(8'hFF);
        commit();
        check("R4 saturation", 40'h08_0102_0304);

        // R5: staged word kept, second commit repeats it; pointer re-armed
        commit();
        check("R5 staged kept", 40'h08_0102_0304);
        load5(40'h10_A0B0_C0D0);
        commit();
        check("R5 pointer re-armed", 40'h10_A0B0_C0D0);

        // R8 pointer still cleared after refused commit
        load5(40'h01_1111_1111);
        commit();
        check("R8 refused", 40'h10_A0B0_C0D0);
        load5(40'h18_2222_2222);
        commit();
        check("R8 pointer cleared", 40'h18_2222_2222);

        // R9: coincident edges, byte dropped
        load5(40'h00_1234_5678);
        commit();
        din = 8'h08; wclk_in = 1'b1; upd_in = 1'b1; tick();
        wclk_in = 1'b0; upd_in = 1'b0; tick();
        commit();
        check("R9 coincident", 40'h00_1234_5678);

        // R7: held update level commits once; held word clock counts once
        load5(40'h20_3333_3333);
        upd_in = 1'b1; tick();
        check("R7 first commit", 40'h20_3333_3333);
        din = 8'h28; wclk_in = 1'b1; tick(); tick(); tick(); wclk_in = 1'b0; tick();
        wbyte(8'h44); wbyte(8'h44); wbyte(8'h44); wbyte(8'h44);
        check("R7 level no commit", 40'h20_3333_3333);
        upd_in = 1'b0; tick();
        commit();
        check("R7 held wclk one byte", 40'h28_4444_4444);

        // R6: serial, two junk bits pushed out, value sent bit 0 first
        begin
            logic [39:0] v;
            v = 40'h2C_CAFE_1234;
            ser_mode = 1'b1;
            sbit(1'b1); sbit(1'b1);
            for (int k = 0; k < 40; k++) sbit(v[k]);
            commit();
            check("R6 serial", v);
        end
        ser_mode = 1'b0;

        // R1: reset mid-load clears pointer and outputs
        wbyte(8'h30); wbyte(8'h55);
        do_reset();
        check("R1 reset clears", 40'h0);
        load5(40'h30_0000_00AB);
        commit();
        check("R1 pointer from first byte", 40'h30_0000_00AB);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule